// File: doc/BRIEF.md
# Periodic Countdown Timer with Sticky Interrupt Flag

This block is a programmable fixed-period timer. Software loads an 8-bit period value, turns the timer on, and the counter then steps down by one on every source-clock tick strobe. Each time the count steps to zero, a sticky event flag is set. The flag drives an open-drain style interrupt that is active low, modelled as an output-enable together with the level it would drive. The flag stays set until software clears it. The timer keeps running while the flag is set, and it raises the flag again at the end of the next period.

Software reaches the block through a two-entry register window with a one-bit address. Entry 0 is the control/status word: bit 0 is the run enable and bit 1 is the event flag. Entry 1 is the period/count register. A write to entry 1 loads the period. A read of entry 1 returns the live count, which is not latched. Turning the timer off discards both the period and the current count. A fresh period must therefore be written while the timer is stopped before it can run again.

Top module: `tmr_periodic`

## Requirements
- R1: After reset, the control/status read is 00h, the count read is 00h, irq_oe_o is 0 and irq_n_o is 1.
- R2: While run is 0, writing a nonzero value to entry 1 stores it as the period, and the count read shows it one cycle later. A write of 00h is ignored. A write to entry 1 while run is 1 is ignored.
- R3: While run is 1 and a valid period is held, the count drops by one on each cycle with tick_i high. It holds on cycles without a tick. A read of entry 1 returns this live value.
- R4: A tick that moves the count to 00h sets the flag (status bit 1). The next tick reloads the count from the period and decrements it in the same step, so the count goes to period-1 and expiries come exactly every period ticks. A period of 1 expires on every tick.
- R5: The flag is cleared only by a write to entry 0 with bit 1 at 0. A write with bit 1 at 1 leaves the flag unchanged, whether it is set or clear.
- R6: irq_oe_o is 1 and irq_n_o is 0 exactly while the flag is set. Otherwise irq_oe_o is 0 and irq_n_o is 1.
- R7: Clearing the flag does not stop the count. The next expiry sets the flag again.
- R8: Writing run from 1 to 0 makes the count read 00h and invalidates the period. Setting run to 1 again without a new period write leaves the counter at 00h, and no flag is set however many ticks arrive.
- R9: When a flag-clearing write and an expiry fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Source-clock tick strobe, one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control/status, 1 period/count |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_oe_o | output | 1 | Interrupt pin driver enable (1 = pulling low) |
| irq_n_o | output | 1 | Interrupt level, low while the flag is set |

## Verification
Every register update lands on the clock edge that follows the stimulus cycle, and reads are combinational. A write or tick therefore shows on rdata_o or on the interrupt pins one edge later. The driver applies inputs at the falling edge. A check item queued at the next falling edge is compared by the monitor 1 ns after that edge, so it sees exactly one rising edge of effect. Check cycles themselves carry no tick, which also exercises the hold case of R3. The same-cycle clear-and-expiry case is driven as a single cycle that carries both the write and the tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned FLAG_BIT = 1;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_cnt_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             run_o,
  output logic             pre_vld_o,
  output logic [CNT_W-1:0] preset_o,
  output logic             load_o,
  output logic             kill_o
);
  logic             run_q;
  logic             vld_q;
  logic [CNT_W-1:0] preset_q;

  // preset accepted only while stopped and nonzero
  assign load_o = wr_cnt_i && !run_q && (wdata_i != '0);
  assign kill_o = wr_ctrl_i && run_q && !wdata_i[RUN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      vld_q    <= 1'b0;
      preset_q <= '0;
    end else begin
      if (wr_ctrl_i) run_q <= wdata_i[RUN_BIT];
      if (kill_o) begin
        vld_q    <= 1'b0;
        preset_q <= '0;
      end else if (load_o) begin
        vld_q    <= 1'b1;
        preset_q <= wdata_i;
      end
    end
  end

  assign run_o     = run_q;
  assign pre_vld_o = vld_q;
  assign preset_o  = preset_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pre_vld_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             kill_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;
  logic             step;

  assign step = run_i && pre_vld_i && tick_i;

  // a zero count reloads and decrements in the same tick: period = preset
  always_comb begin
    base = (cnt_q == '0) ? preset_i : cnt_q;
    nxt  = base - 1'b1;
  end

  assign expire_o = step && (nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (kill_i) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_oe_o,
  output logic irq_n_o
);
  logic flag_q;

  // expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o   = flag_q;
  assign irq_oe_o = flag_q;
  assign irq_n_o  = ~flag_q;
endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_oe_o,
  output logic             irq_n_o
);
  localparam int unsigned PAD_W = CNT_W - 2;

  logic             wr_ctrl, wr_cnt;
  logic             run, pre_vld, load, kill, expire, flag, clr;
  logic [CNT_W-1:0] preset, cnt;

  assign wr_ctrl = wr_en_i && (addr_i == SEL_CTRL);
  assign wr_cnt  = wr_en_i && (addr_i == SEL_CNT);
  assign clr     = wr_ctrl && !wdata_i[FLAG_BIT];

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_ctrl_i (wr_ctrl),
    .wr_cnt_i  (wr_cnt),
    .wdata_i,
    .run_o     (run),
    .pre_vld_o (pre_vld),
    .preset_o  (preset),
    .load_o    (load),
    .kill_o    (kill)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i      (run),
    .pre_vld_i  (pre_vld),
    .preset_i   (preset),
    .tick_i,
    .load_i     (load),
    .load_val_i (wdata_i),
    .kill_i     (kill),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  tmr_irq u_irq (
    .clk_i, .rst_ni,
    .expire_i (expire),
    .clr_i    (clr),
    .flag_o   (flag),
    .irq_oe_o,
    .irq_n_o
  );

  always_comb begin
    if (addr_i == SEL_CNT) rdata_o = cnt;
    else                   rdata_o = {{PAD_W{1'b0}}, flag, run};
  end
endmodule

// File: rtl/tmr_periodic_chk.sv
module tmr_periodic_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic             addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             irq_oe_o,
  input logic             run,
  input logic             pre_vld,
  input logic             expire,
  input logic [CNT_W-1:0] cnt
);
  logic clr_wr;
  assign clr_wr = wr_en_i && !addr_i && !wdata_i[1];

  AST_RESET_RELEASED: assert property (@(posedge clk_i) !rst_ni |-> !irq_oe_o) // R1
    else $error("irq driven in reset");
  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && wr_en_i && addr_i && wdata_i != '0) |=> cnt == $past(wdata_i)) // R2
    else $error("preset not loaded");
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && pre_vld && tick_i && cnt > 1 && !wr_en_i) |=> cnt == $past(cnt) - 1'b1) // R3
    else $error("count did not step");
  AST_EXPIRY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> irq_oe_o && cnt == '0) // R4
    else $error("expiry lost");
  AST_STICKY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_oe_o && !clr_wr) |=> irq_oe_o) // R5
    else $error("flag dropped without clear");
  AST_RISE_FROM_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_oe_o) |-> $past(expire)) // R6
    else $error("irq rose without expiry");
  AST_STOP_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run) |-> (cnt == '0 && !pre_vld)) // R8
    else $error("stop kept count");
  AST_EXPIRY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && clr_wr) |=> irq_oe_o) // R9
    else $error("clear beat expiry");
endmodule

bind tmr_periodic tmr_periodic_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .addr_i, .wdata_i, .irq_oe_o,
  .run, .pre_vld, .expire, .cnt
);

// File: tb/tmr_periodic_test.sv
`timescale 1ns/1ps
module tmr_periodic_test;
  localparam int KIND_STAT = 0;
  localparam int KIND_CNT  = 1;
  localparam int KIND_IRQ  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_oe, irq_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  tmr_periodic uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_oe_o(irq_oe), .irq_n_o(irq_n)
  );

  task automatic cyc(input logic w, input logic a, input logic [7:0] d, input logic t);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = t;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  // driver: idle cycle, select the view, queue the expected item
  task automatic chk(input string tag, input int kind, input logic [7:0] e);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    addr = (kind == KIND_CNT);
    it.tag = tag; it.kind = kind; it.exp = e;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = (it.kind == KIND_IRQ) ? {6'b0, irq_oe, irq_n} : rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #80000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 status", KIND_STAT, 8'h00);
    chk("R1 count", KIND_CNT, 8'h00);
    chk("R1 irq", KIND_IRQ, 8'h01);

    cyc(1, 1, 8'h00, 0); chk("R2 zero ignored", KIND_CNT, 8'h00);
    cyc(1, 1, 8'h05, 0); chk("R2 preset", KIND_CNT, 8'h05);
    cyc(1, 0, 8'h01, 0); chk("R2 run on", KIND_STAT, 8'h01);

    ticks(1); chk("R3 step", KIND_CNT, 8'h04);
    chk("R3 hold", KIND_CNT, 8'h04);
    cyc(1, 1, 8'h09, 0); chk("R2 write while running", KIND_CNT, 8'h04);

    ticks(3); chk("R3 live", KIND_CNT, 8'h01);
    chk("R4 no flag yet", KIND_STAT, 8'h01);
    ticks(1); chk("R4 zero", KIND_CNT, 8'h00);
    chk("R4 flag", KIND_STAT, 8'h03);
    chk("R6 irq low", KIND_IRQ, 8'h02);

    ticks(1); chk("R4 reload", KIND_CNT, 8'h04);
    ticks(4); chk("R4 period", KIND_CNT, 8'h00);

    cyc(1, 0, 8'h03, 0); chk("R5 write one keeps", KIND_STAT, 8'h03);
    cyc(1, 0, 8'h01, 0); chk("R5 clear", KIND_STAT, 8'h01);
    chk("R6 released", KIND_IRQ, 8'h01);

    ticks(4); chk("R7 running", KIND_CNT, 8'h01);
    ticks(1); chk("R7 flag again", KIND_STAT, 8'h03);

    cyc(1, 0, 8'h01, 0);
    ticks(4); chk("R9 setup", KIND_CNT, 8'h01);
    cyc(1, 0, 8'h01, 1); chk("R9 expiry wins", KIND_STAT, 8'h03);
    chk("R9 count", KIND_CNT, 8'h00);

    cyc(1, 0, 8'h01, 0);
    cyc(1, 0, 8'h03, 0); chk("R5 one does not set", KIND_STAT, 8'h01);

    cyc(1, 0, 8'h00, 0); chk("R8 stopped", KIND_STAT, 8'h00);
    chk("R8 count cleared", KIND_CNT, 8'h00);
    cyc(1, 0, 8'h01, 0);
    ticks(10); chk("R8 idle", KIND_CNT, 8'h00);
    chk("R8 no flag", KIND_STAT, 8'h01);
    chk("R8 irq released", KIND_IRQ, 8'h01);

    cyc(1, 0, 8'h00, 0);
    cyc(1, 1, 8'h01, 0);
    cyc(1, 0, 8'h01, 0); chk("R2 reload after stop", KIND_CNT, 8'h01);
    ticks(1); chk("R4 period one", KIND_STAT, 8'h03);
    cyc(1, 0, 8'h01, 0);
    ticks(1); chk("R4 period one again", KIND_STAT, 8'h03);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule